// File: doc/BRIEF.md
# Two-Line Peripheral Interrupt Aggregator

This block takes up to 32 interrupt requests from audio peripherals and presents them to a host core as two lines: one high-priority, one low-priority. Each source latches into a status bit. The source raises a line only if software has enabled it. A per-source priority bit picks which of the two lines it drives.

By default, sources 0..7 carry DMA-channel requests and 8..9 carry FIFO status. Sources 10..19 are miscellaneous events, 20..27 are receiver status and 28..31 come from rate converters. Only the miscellaneous group (bits 10..19, set by the `EDGE_CAP` parameter) is edge-capable. For these sources a polarity bit selects rising or falling edge, and the status bit stays set until software writes a one to it. All other sources are level-sensitive: their status bit follows the input.

Software uses a small write/read register port. Selector 0 is the priority map, 1 is the enable map, 2 is the polarity map and 3 is the status word, which is write-one-to-clear. Bit i of each word belongs to source i. Reads are combinational on the selector.

Top module: `irq_agg`

## Requirements
- R1: After reset, the enable, priority, polarity and status words all read 0 and both output lines are low. Enable 0 means the source is masked, priority 0 means the low line, and polarity 0 means rising edge.
- R2: A write with `reg_we` high stores `reg_wdata` into the word named by `reg_addr`: 0 is priority, 1 is enable, 2 is polarity. The new value reads back from the next cycle on.
- R3: Polarity bits exist only for edge-capable sources (bits 10..19 by default). Other polarity bits always read 0.
- R4: On an edge-capable source with polarity 0, a 0-to-1 input change sets its status bit. The new bit value reads back after the clock edge that samples the new input.
- R5: On an edge-capable source with polarity 1, only a 1-to-0 change sets the status bit. A rising change has no effect on status.
- R6: The status bit of an edge-capable source stays set until a status write has a 1 in that bit position. Writing 0 there, or the input going back, leaves it set.
- R7: If an edge and a clearing write to the same bit arrive in the same cycle, the bit stays set.
- R8: The status bit of a level source equals its input as sampled at the last clock edge. A clearing write does not drop it while the input is high.
- R9: `irq_hi_o` goes high one clock after any status bit is set that is both enabled and has priority 1. It goes low one clock after no such bit remains.
- R10: `irq_lo_o` behaves the same way for status bits that are enabled and have priority 0.
- R11: A masked source never raises either line. Its status bit still latches and reads back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Interrupt request inputs, bit i is source i |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word selector: 0 priority, 1 enable, 2 polarity, 3 status |
| reg_wdata | input | DATA_W | Write data, bit i belongs to source i |
| reg_rdata | output | DATA_W | Read data of the selected word, zero above N_SRC |
| irq_hi_o | output | 1 | Registered high-priority interrupt line |
| irq_lo_o | output | 1 | Registered low-priority interrupt line |

## Verification
Source inputs and register writes are applied after a falling edge and are sampled at the next rising edge. The status word and the configuration words therefore read back right after that edge. The two lines follow status, enable and priority one further rising edge later. The bench's behavioural model applies exactly this timing. It is compared half a period after each rising edge, both on the lines and on whichever word is selected. The directed checks step one edge for a status result and two edges for a line result before sampling.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef enum logic [1:0] {
    SEL_PRIO   = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_POLAR  = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  // Edge seen between last sampled value and current input.
  function automatic logic edge_seen(logic prev, logic cur, logic falling);
    return falling ? (prev & ~cur) : (~prev & cur);
  endfunction

  // Next status value: sticky with W1C for edge sources, copy for level ones.
  function automatic logic next_status(logic edge_src, logic cur_status,
                                       logic hit, logic clr, logic level_in);
    return edge_src ? (hit | (cur_status & ~clr)) : level_in;
  endfunction

  // Does this source contribute to the requested line?
  function automatic logic line_hit(logic status, logic enable, logic prio,
                                    logic want_hi);
    return status & enable & (prio == want_hi);
  endfunction

endpackage

// File: rtl/irq_agg_cfg.sv
module irq_agg_cfg
  import irq_agg_pkg::*;
#(
  parameter int               N_SRC    = 32,
  parameter logic [N_SRC-1:0] EDGE_CAP = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] prio_o,
  output logic [N_SRC-1:0] enable_o,
  output logic [N_SRC-1:0] polar_o
);

  logic prio_we, enable_we, polar_we;
  assign prio_we   = wr_en && (wr_sel == SEL_PRIO);
  assign enable_we = wr_en && (wr_sel == SEL_ENABLE);
  assign polar_we  = wr_en && (wr_sel == SEL_POLAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_o   <= '0;
      enable_o <= '0;
    end else begin
      if (prio_we)   prio_o   <= wdata;
      if (enable_we) enable_o <= wdata;
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_pol
    if (EDGE_CAP[i]) begin : g_cap
      logic pol_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pol_q <= 1'b0;
        else if (polar_we) pol_q <= wdata[i];
      end
      assign polar_o[i] = pol_q;
    end else begin : g_none
      assign polar_o[i] = 1'b0;
    end
  end

  // R3
  polar_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    polar_we |=> ((polar_o & ~EDGE_CAP) == '0));

endmodule

// File: rtl/irq_agg_detect.sv
module irq_agg_detect
  import irq_agg_pkg::*;
#(
  parameter int               N_SRC    = 32,
  parameter logic [N_SRC-1:0] EDGE_CAP = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] polar_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] status_o,
  output logic [N_SRC-1:0] edge_o
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic st_q;
    if (EDGE_CAP[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_i[i];
      end
      assign edge_o[i] = edge_seen(prev_q, src_i[i], polar_i[i]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= 1'b0;
        else        st_q <= next_status(1'b1, st_q, edge_o[i], clr_i[i], src_i[i]);
      end
    end else begin : g_level
      logic unused_polar;
      assign unused_polar = polar_i[i];
      assign edge_o[i]    = 1'b0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= 1'b0;
        else        st_q <= next_status(1'b0, st_q, 1'b0, clr_i[i], src_i[i]);
      end
    end
    assign status_o[i] = st_q;
  end

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & $past(status_o & ~clr_i & EDGE_CAP))
              == $past(status_o & ~clr_i & EDGE_CAP)));

  // R7
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & $past(edge_o)) == $past(edge_o)));

endmodule

// File: rtl/irq_agg_route.sv
module irq_agg_route
  import irq_agg_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] status_i,
  input  logic [N_SRC-1:0] enable_i,
  input  logic [N_SRC-1:0] prio_i,
  output logic             hi_o,
  output logic             lo_o
);

  logic [N_SRC-1:0] hi_hit, lo_hit;

  for (genvar i = 0; i < N_SRC; i++) begin : g_hit
    assign hi_hit[i] = line_hit(status_i[i], enable_i[i], prio_i[i], 1'b1);
    assign lo_hit[i] = line_hit(status_i[i], enable_i[i], prio_i[i], 1'b0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_o <= 1'b0;
      lo_o <= 1'b0;
    end else begin
      hi_o <= |hi_hit;
      lo_o <= |lo_hit;
    end
  end

  // R9
  hi_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_i & enable_i & prio_i)) |=> hi_o);

  // R10
  lo_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_i & enable_i & ~prio_i)) |=> lo_o);

  // R11
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i == '0) |=> (!hi_o && !lo_o));

endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int               N_SRC    = 32,
  parameter int               DATA_W   = 32,
  parameter logic [N_SRC-1:0] EDGE_CAP = 32'h000F_FC00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_hi_o,
  output logic              irq_lo_o
);

  reg_sel_e         sel;
  logic [N_SRC-1:0] wdata_src;
  logic [N_SRC-1:0] prio, enable, polar, status, edge_hit, clr;

  assign sel       = reg_sel_e'(reg_addr);
  assign wdata_src = reg_wdata[N_SRC-1:0];
  assign clr       = (reg_we && sel == SEL_STATUS) ? wdata_src : '0;

  irq_agg_cfg #(.N_SRC(N_SRC), .EDGE_CAP(EDGE_CAP)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_we),
    .wr_sel   (sel),
    .wdata    (wdata_src),
    .prio_o   (prio),
    .enable_o (enable),
    .polar_o  (polar)
  );

  irq_agg_detect #(.N_SRC(N_SRC), .EDGE_CAP(EDGE_CAP)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_i),
    .polar_i  (polar),
    .clr_i    (clr),
    .status_o (status),
    .edge_o   (edge_hit)
  );

  irq_agg_route #(.N_SRC(N_SRC)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status),
    .enable_i (enable),
    .prio_i   (prio),
    .hi_o     (irq_hi_o),
    .lo_o     (irq_lo_o)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_PRIO:   reg_rdata[N_SRC-1:0] = prio;
      SEL_ENABLE: reg_rdata[N_SRC-1:0] = enable;
      SEL_POLAR:  reg_rdata[N_SRC-1:0] = polar;
      SEL_STATUS: reg_rdata[N_SRC-1:0] = status;
    endcase
  end

endmodule

// File: tb/irq_agg_bench.sv
`timescale 1ns/1ps
module irq_agg_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_v = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd3;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        hi, lo;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_agg u_irq_agg (
    .clk(clk), .rst_n(rst_n), .src_i(src_v), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_hi_o(hi), .irq_lo_o(lo)
  );

  // Reference model: bit vectors updated with plain per-source loops.
  bit [31:0] m_cap, m_prio, m_en, m_pol, m_st, m_prev;
  bit        m_hi, m_lo;

  initial begin
    m_cap = '0;
    for (int i = 10; i <= 19; i++) m_cap[i] = 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prio = '0; m_en = '0; m_pol = '0; m_st = '0; m_prev = '0;
      m_hi = 0; m_lo = 0;
    end else begin
      m_hi = 0; m_lo = 0;
      for (int i = 0; i < 32; i++)
        if (m_st[i] && m_en[i]) begin
          if (m_prio[i]) m_hi = 1; else m_lo = 1;
        end
      for (int i = 0; i < 32; i++) begin
        if (m_cap[i]) begin
          bit e, c;
          e = m_pol[i] ? (m_prev[i] && !src_v[i]) : (!m_prev[i] && src_v[i]);
          c = we && addr == 2'd3 && wdata[i];
          if (e) m_st[i] = 1;
          else if (c) m_st[i] = 0;
        end else begin
          m_st[i] = src_v[i];
        end
        m_prev[i] = src_v[i];
      end
      if (we && addr == 2'd0) m_prio = wdata;
      if (we && addr == 2'd1) m_en = wdata;
      if (we && addr == 2'd2) m_pol = wdata & m_cap;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison half a period after each rising edge.
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R9 hi line vs model", {31'b0, hi}, {31'b0, m_hi});
      check("R10 lo line vs model", {31'b0, lo}, {31'b0, m_lo});
      case (addr)
        2'd0: check("R2 prio vs model", rdata, m_prio);
        2'd1: check("R2 enable vs model", rdata, m_en);
        2'd2: check("R3 polarity vs model", rdata, m_pol);
        default: check("R4 status vs model", rdata, m_st);
      endcase
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0; addr = 2'd3; wdata = '0;
  endtask

  task automatic rd(string tag, logic [1:0] a, logic [31:0] exp);
    addr = a;
    #2;
    check(tag, rdata, exp);
    addr = 2'd3;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 hi after reset", {31'b0, hi}, 32'h0);
    check("R1 lo after reset", {31'b0, lo}, 32'h0);
    rd("R1 prio reset", 2'd0, 32'h0);
    rd("R1 enable reset", 2'd1, 32'h0);
    rd("R1 polarity reset", 2'd2, 32'h0);
    rd("R1 status reset", 2'd3, 32'h0);

    // R2 configuration writes
    wr(2'd0, 32'h0000_0400);
    wr(2'd1, 32'h0000_0C01);
    rd("R2 prio readback", 2'd0, 32'h0000_0400);
    rd("R2 enable readback", 2'd1, 32'h0000_0C01);

    // R3 polarity only on capable bits
    wr(2'd2, 32'hFFFF_FFFF);
    rd("R3 polarity masked to capable", 2'd2, 32'h000F_FC00);
    wr(2'd2, 32'h0000_0800);
    rd("R3 polarity readback", 2'd2, 32'h0000_0800);

    // R4 rising edge on source 10
    src_v[10] = 1'b1;
    step();
    rd("R4 rising edge latched", 2'd3, 32'h0000_0400);
    check("R9 hi not yet", {31'b0, hi}, 32'h0);
    step();
    check("R9 hi raised", {31'b0, hi}, 32'h1);
    check("R10 lo quiet", {31'b0, lo}, 32'h0);

    // R6 sticky behaviour
    src_v[10] = 1'b0;
    step();
    rd("R6 sticky after input drop", 2'd3, 32'h0000_0400);
    wr(2'd3, 32'h0);
    rd("R6 zero write keeps bit", 2'd3, 32'h0000_0400);
    wr(2'd3, 32'h0000_0400);
    rd("R6 one write clears bit", 2'd3, 32'h0);
    check("R9 hi still from old status", {31'b0, hi}, 32'h1);
    step();
    check("R9 hi dropped", {31'b0, hi}, 32'h0);

    // R5 falling edge on source 11
    src_v[11] = 1'b1;
    step();
    rd("R5 rising ignored", 2'd3, 32'h0);
    src_v[11] = 1'b0;
    step();
    rd("R5 falling latched", 2'd3, 32'h0000_0800);
    step();
    check("R10 lo raised", {31'b0, lo}, 32'h1);
    check("R9 hi quiet", {31'b0, hi}, 32'h0);
    wr(2'd3, 32'h0000_0800);
    step();
    check("R10 lo dropped", {31'b0, lo}, 32'h0);

    // R7 edge and clear in the same cycle
    src_v[10] = 1'b1;
    we = 1'b1; addr = 2'd3; wdata = 32'h0000_0400;
    step();
    we = 1'b0; wdata = '0;
    rd("R7 edge beats clear", 2'd3, 32'h0000_0400);
    wr(2'd3, 32'h0000_0400);
    rd("R7 later clear works", 2'd3, 32'h0);
    src_v[10] = 1'b0;
    step();

    // R8 level source 0
    src_v[0] = 1'b1;
    step();
    rd("R8 level follows input", 2'd3, 32'h0000_0001);
    step();
    check("R10 lo from level source", {31'b0, lo}, 32'h1);
    wr(2'd3, 32'h0000_0001);
    rd("R8 clear ignored while high", 2'd3, 32'h0000_0001);
    src_v[0] = 1'b0;
    step();
    rd("R8 drops with input", 2'd3, 32'h0);
    step();

    // R11 masked source 5
    src_v[5] = 1'b1;
    wr(2'd0, 32'h0000_0420);
    step();
    rd("R11 masked status latches", 2'd3, 32'h0000_0020);
    check("R11 masked hi quiet", {31'b0, hi}, 32'h0);
    check("R11 masked lo quiet", {31'b0, lo}, 32'h0);
    src_v[5] = 1'b0;
    step();

    // Mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      src_v = src_v ^ ($urandom & $urandom & $urandom);
      if (($urandom % 5) == 0) begin
        we = 1'b1;
        addr = 2'($urandom % 4);
        wdata = $urandom;
      end else begin
        we = 1'b0;
        addr = 2'($urandom % 4);
        wdata = '0;
      end
      step();
    end
    we = 1'b0;
    step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule